// File: doc/BRIEF.md
# Stereo Channel-Select Generator

This block turns a frame-sync pulse into the left/right select line that an interleaved stereo DAC needs. A serial audio source sends one 32-bit word per stereo sample. The first 16 bits belong to the left channel and the next 16 to the right. The source marks only the start of each word, with a one-bit frame-sync pulse. The block counts serial bits from that pulse. It drives the select at the left level for the first half of the frame and at the right level for the second half.

All of the block's logic runs on the serial bit clock that the source supplies, so it follows whatever bit rate the source picks for its sample rate. Frame sync is sampled on the rising edge of that clock, which is the same edge at which the DAC samples data. Once a full frame has been counted, the block holds its select and waits for the next pulse. A pulse that arrives early starts a new frame at once.

Top module: `stereo_select_gen`

## Requirements
- R1: While reset is low, and after reset is released until the first frame-sync pulse is sampled, the select output is at the left level.
- R2: On a rising clock edge at which `fsync_i` is high, the select output becomes the left level after that edge.
- R3: The edge that samples frame sync and the next HALF_BITS-1 edges (HALF_BITS edges in all, 16 by default) leave the select at the left level. The HALF_BITS-th edge after the sync edge switches it to the right level.
- R4: The right level then holds for HALF_BITS edges, so a frame covers 2*HALF_BITS edges (32 by default).
- R5: After a full frame with no new frame sync, the select stays at the right level on every later edge until a frame-sync pulse is sampled.
- R6: A frame-sync pulse sampled at any point within a frame, including on consecutive edges, restarts the frame: the select goes to the left level and counting starts again from the sync edge.
- R7: Parameter LEFT_LEVEL sets the left level of the select, and the right level is its complement. The default is 1 (high = left).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk_i | input | 1 | Serial bit clock from the source; rising edge samples everything |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame-sync pulse marking the first bit of a stereo word |
| ch_sel_o | output | 1 | Channel select to the DAC (LEFT_LEVEL = left) |

## Verification
The hardest situations to reach are frame-sync pulses at every possible offset within a running frame, including the exact switch edge and the edge just after the frame ends. Also hard is a frame-sync pulse on the very edge where the counter reaches its limit. The bench steps the gap between successive pulses through every value from 1 to 40 edges, so each position, each early restart and each late restart is covered once. It also applies a reset in the middle of a frame. A second instance with the opposite polarity and a shorter frame runs on the same stimulus and is checked against the same arithmetic model.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

    typedef enum logic [1:0] {
        SSG_WAIT  = 2'd0,
        SSG_LEFT  = 2'd1,
        SSG_RIGHT = 2'd2
    } ssg_phase_e;

endpackage

// File: rtl/ssg_bit_counter.sv
module ssg_bit_counter #(
    parameter int HALF_BITS = 16,
    localparam int FRAME_BITS = 2 * HALF_BITS,
    localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic             advance_i,
    output logic             half_o,
    output logic             full_o,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.cnt = CNT_W'(1);
        end else if (advance_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign half_o  = (st_q.cnt == CNT_W'(HALF_BITS));
    assign full_o  = (st_q.cnt == CNT_W'(FRAME_BITS));
    assign count_o = st_q.cnt;

endmodule

// File: rtl/ssg_phase_ctrl.sv
module ssg_phase_ctrl
    import ssg_pkg::*;
#(
    parameter bit LEFT_LEVEL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fsync_i,
    input  logic half_i,
    input  logic full_i,
    output logic restart_o,
    output logic advance_o,
    output logic sel_o
);

    localparam bit RIGHT_LEVEL = ~LEFT_LEVEL;

    typedef struct packed {
        ssg_phase_e phase;
        logic       sel;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fsync_i) begin
            st_d.phase = SSG_LEFT;
            st_d.sel   = LEFT_LEVEL;
        end else begin
            unique case (st_q.phase)
                SSG_LEFT: begin
                    if (half_i) begin
                        st_d.phase = SSG_RIGHT;
                        st_d.sel   = RIGHT_LEVEL;
                    end
                end
                SSG_RIGHT: begin
                    if (full_i) begin
                        st_d.phase = SSG_WAIT;
                    end
                end
                default: begin
                    st_d.phase = SSG_WAIT;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase <= SSG_WAIT;
            st_q.sel   <= LEFT_LEVEL;
        end else begin
            st_q <= st_d;
        end
    end

    assign restart_o = fsync_i;
    assign advance_o = (st_q.phase != SSG_WAIT) && !full_i;
    assign sel_o     = st_q.sel;

endmodule

// File: rtl/stereo_select_gen.sv
module stereo_select_gen #(
    parameter int HALF_BITS  = 16,
    parameter bit LEFT_LEVEL = 1'b1,
    localparam int FRAME_BITS = 2 * HALF_BITS,
    localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
    input  logic sclk_i,
    input  logic rst_ni,
    input  logic fsync_i,
    output logic ch_sel_o
);

    logic             restart;
    logic             advance;
    logic             at_half;
    logic             at_full;
    logic [CNT_W-1:0] bit_count;

    ssg_bit_counter #(
        .HALF_BITS (HALF_BITS)
    ) u_cnt (
        .clk_i     (sclk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .advance_i (advance),
        .half_o    (at_half),
        .full_o    (at_full),
        .count_o   (bit_count)
    );

    ssg_phase_ctrl #(
        .LEFT_LEVEL (LEFT_LEVEL)
    ) u_ctrl (
        .clk_i     (sclk_i),
        .rst_ni    (rst_ni),
        .fsync_i   (fsync_i),
        .half_i    (at_half),
        .full_i    (at_full),
        .restart_o (restart),
        .advance_o (advance),
        .sel_o     (ch_sel_o)
    );

endmodule

// File: rtl/ssg_checker.sv
module ssg_checker #(
    parameter int HALF_BITS  = 16,
    parameter bit LEFT_LEVEL = 1'b1,
    localparam int FRAME_BITS = 2 * HALF_BITS,
    localparam int CNT_W = $clog2(FRAME_BITS + 1),
    localparam int CW = $clog2(FRAME_BITS + 2)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             fsync_i,
    input logic             ch_sel_o,
    input logic [CNT_W-1:0] count_i
);

    logic [CW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (fsync_i) begin
            gap_q  <= CW'(1);
            seen_q <= 1'b1;
        end else if (seen_q && gap_q <= CW'(FRAME_BITS)) begin
            gap_q  <= gap_q + CW'(1);
        end
    end

    // R1: before any frame sync the select sits at the left level
    p_idle_left_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !seen_q |-> ch_sel_o == LEFT_LEVEL);

    // R2, R6: a sampled sync forces left on the following cycle
    p_sync_left_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fsync_i |=> ch_sel_o == LEFT_LEVEL);

    // R3: the half-way edge turns the select to the right level
    p_switch_right_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seen_q && gap_q == CW'(HALF_BITS) && !fsync_i |=> ch_sel_o == !LEFT_LEVEL);

    // R4, R5: no other edge without sync moves the select
    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!seen_q || gap_q != CW'(HALF_BITS)) && !fsync_i |=> $stable(ch_sel_o));

    // R4: the internal bit count never passes a full frame
    p_count_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_i <= CNT_W'(FRAME_BITS));

endmodule

bind stereo_select_gen ssg_checker #(
    .HALF_BITS  (HALF_BITS),
    .LEFT_LEVEL (LEFT_LEVEL)
) u_ssg_chk (
    .clk_i    (sclk_i),
    .rst_ni   (rst_ni),
    .fsync_i  (fsync_i),
    .ch_sel_o (ch_sel_o),
    .count_i  (bit_count)
);

// File: tb/stereo_select_gen_bench.sv
`timescale 1ns/1ps
module stereo_select_gen_bench;

    localparam int HALF_A = 16;
    localparam int HALF_B = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0;
    logic sel_a, sel_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit started = 1'b0;
    int k = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stereo_select_gen u_stereo_select_gen (
        .sclk_i   (clk),
        .rst_ni   (rst_n),
        .fsync_i  (fsync),
        .ch_sel_o (sel_a)
    );

    stereo_select_gen #(.HALF_BITS(HALF_B), .LEFT_LEVEL(1'b0)) u_stereo_select_gen_inv (
        .sclk_i   (clk),
        .rst_ni   (rst_n),
        .fsync_i  (fsync),
        .ch_sel_o (sel_b)
    );

    function automatic string tag_of(int half);
        if (!started)        return "R1";
        if (k == 0)          return "R2/R6";
        if (k < half)        return "R3";
        if (k < 2 * half)    return "R4";
        return "R5";
    endfunction

    task automatic check_now();
        logic exp_a, exp_b;
        exp_a = (!started || k < HALF_A) ? 1'b1 : 1'b0;
        exp_b = (!started || k < HALF_B) ? 1'b0 : 1'b1;
        n_tests++;
        if (sel_a !== exp_a) begin
            n_fail++;
            $display("FAIL %s: k=%0d sel=%b expected %b", tag_of(HALF_A), k, sel_a, exp_a);
        end
        n_tests++;
        if (sel_b !== exp_b) begin
            n_fail++;
            $display("FAIL R7 (%s): inverted k=%0d sel=%b expected %b",
                     tag_of(HALF_B), k, sel_b, exp_b);
        end
    endtask

    // check the result of the previous edge, then drive for the next one
    task automatic step(input bit fs);
        @(negedge clk);
        check_now();
        fsync = fs;
        if (fs) begin
            started = 1'b1;
            k = 0;
        end else if (started && k < 1000) begin
            k++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_now();                  // R1 during reset
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) step(1'b0);   // R1 idle after reset
        for (int gap = 1; gap <= 40; gap++) begin // R2..R6 sweep
            step(1'b1);
            for (int j = 1; j < gap; j++) step(1'b0);
        end
        for (int i = 0; i < 45; i++) step(1'b0);  // R5 long hold
        step(1'b1);
        for (int i = 0; i < 20; i++) step(1'b0);
        @(negedge clk);
        check_now();
        rst_n = 1'b0;                              // R1 mid-frame reset
        fsync = 1'b0;
        started = 1'b0;
        k = 0;
        #1;
        check_now();
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) step(1'b0);
        step(1'b1);
        for (int i = 0; i < 36; i++) step(1'b0);
        @(negedge clk);
        check_now();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: run did not finish, got timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule